// File: doc/BRIEF.md
# Multi-Master Physical Address Router

This block sits between a CPU master, a DMA read master and a set of downstream targets: a word-wide RAM, the register shell of a DMA channel and one auxiliary peripheral shell. Every CPU access is decoded from its 32-bit physical address into a region and then forwarded. The access goes to the matching target with its write data, byte enables and, for RAM reads, the identifier of the requesting master. Read data returns to the requester one cycle after the access reaches its target.

The DMA master can only read, and its requests go to the RAM read port. When both masters want that port in the same cycle, the DMA request wins. The CPU read is then parked inside the router and issued on the first cycle the DMA master leaves the port free. Each master has its own trace lane. A lane emits one event per access. The event carries the region code, the master identifier, the direction and the address.

Top module: `phys_addr_router`

## Requirements
- R1: An address with bits 31..21 all zero is RAM. A CPU write there raises `ram_wr_en` in the same cycle, with `ram_wr_addr` equal to address bits 20..2 followed by two zero bits, and with the CPU data and byte enables passed through unchanged.
- R2: Addresses 0x1F80_1520 to 0x1F80_152F select the DMA register shell. The router raises `dreg_rd_en` or `dreg_wr_en` in the same cycle, with `sh_offset` equal to address bits 3..0. For a read, `dreg_rd_data` is returned to the CPU on the following cycle.
- R3: A CPU read that does not collide with a DMA RAM read gives `cpu_rd_valid` high exactly one cycle after the request, together with the data the addressed target delivered in that cycle.
- R4: A DMA read to RAM drives `ram_rd_en` in the same cycle with the DMA word address and `ram_rd_master` = 4. `dma_rd_valid` follows one cycle later with the RAM data. A DMA read outside RAM touches no target and returns 0 with valid.
- R5: When a CPU RAM read and a DMA RAM read fall in the same cycle, the DMA read uses the port. The CPU read waits until the first cycle without a DMA RAM read. It is then issued with `ram_rd_master` = 2, and its valid comes one cycle later.
- R6: An address in no region is unmapped. A read there returns 0 with valid one cycle later. A write there raises no write enable on any target.
- R7: The CPU trace lane raises `cpu_ev_valid` for exactly one cycle, in the cycle after each CPU access is issued to its target. The event carries master 2, the write flag, the address and a region code: 2 for RAM, 4 for the DMA shell, 5 for the auxiliary shell, 0 for unmapped.
- R8: The DMA trace lane raises `dma_ev_valid` for one cycle after each DMA request. The event carries master 4, the address and the region code of that address.
- R9: While `rst_n` is low, no trace event and no read valid is produced, even if requests are presented.
- R10: Addresses 0x1F80_1070 to 0x1F80_107F select the auxiliary shell. The router raises `aux_rd_en` or `aux_wr_en` with `sh_offset` equal to address bits 3..0. For a read, `aux_rd_data` is returned on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_rd_en | input | 1 | CPU read request |
| cpu_wr_en | input | 1 | CPU write request |
| cpu_addr | input | 32 | CPU physical address |
| cpu_wr_data | input | 32 | CPU write data |
| cpu_wr_be | input | 4 | CPU byte enables |
| cpu_rd_data | output | 32 | Read data returned to the CPU |
| cpu_rd_valid | output | 1 | CPU read data valid |
| dma_rd_en | input | 1 | DMA read request |
| dma_rd_addr | input | 32 | DMA physical address |
| dma_rd_data | output | 32 | Read data returned to the DMA master |
| dma_rd_valid | output | 1 | DMA read data valid |
| ram_rd_en | output | 1 | RAM read enable |
| ram_rd_addr | output | RAM_AW | RAM word-aligned byte address for reads |
| ram_rd_master | output | 8 | Identifier of the master owning the RAM read |
| ram_rd_data | input | 32 | RAM read data, one cycle after enable |
| ram_wr_en | output | 1 | RAM write enable |
| ram_wr_addr | output | RAM_AW | RAM word-aligned byte address for writes |
| ram_wr_data | output | 32 | RAM write data |
| ram_wr_be | output | 4 | RAM byte enables |
| sh_offset | output | 4 | Register offset shared by both shells |
| sh_wr_data | output | 32 | Write data shared by both shells |
| sh_wr_be | output | 4 | Byte enables shared by both shells |
| dreg_rd_en | output | 1 | DMA register shell read enable |
| dreg_wr_en | output | 1 | DMA register shell write enable |
| dreg_rd_data | input | 32 | DMA register shell read data, one cycle after enable |
| aux_rd_en | output | 1 | Auxiliary shell read enable |
| aux_wr_en | output | 1 | Auxiliary shell write enable |
| aux_rd_data | input | 32 | Auxiliary shell read data, one cycle after enable |
| cpu_ev_valid | output | 1 | CPU trace event strobe |
| cpu_ev_region | output | 8 | CPU event region code |
| cpu_ev_master | output | 8 | CPU event master identifier |
| cpu_ev_write | output | 1 | CPU event direction, 1 for write |
| cpu_ev_addr | output | 32 | CPU event address |
| dma_ev_valid | output | 1 | DMA trace event strobe |
| dma_ev_region | output | 8 | DMA event region code |
| dma_ev_master | output | 8 | DMA event master identifier |
| dma_ev_addr | output | 32 | DMA event address |

## Verification
The properties take three things for granted about the inputs. The CPU never raises read and write together. It issues nothing further while one of its reads is still waiting for valid. Every target answers exactly one cycle after its enable. The bench keeps to all three. Each CPU task waits for its read valid before the next access starts, and each DMA task occupies one cycle. The only overlapping traffic is the deliberate collision sequence, where the CPU stays idle until its parked read returns. The bench's target models answer one cycle after each enable.

// File: rtl/phys_addr_router.sv
module phys_addr_router #(
  parameter logic [7:0] CPU_ID = 8'd2,
  parameter logic [7:0] DMA_ID = 8'd4,
  parameter int         RAM_AW = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd_en,
  input  logic              cpu_wr_en,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wr_data,
  input  logic [3:0]        cpu_wr_be,
  output logic [31:0]       cpu_rd_data,
  output logic              cpu_rd_valid,
  input  logic              dma_rd_en,
  input  logic [31:0]       dma_rd_addr,
  output logic [31:0]       dma_rd_data,
  output logic              dma_rd_valid,
  output logic              ram_rd_en,
  output logic [RAM_AW-1:0] ram_rd_addr,
  output logic [7:0]        ram_rd_master,
  input  logic [31:0]       ram_rd_data,
  output logic              ram_wr_en,
  output logic [RAM_AW-1:0] ram_wr_addr,
  output logic [31:0]       ram_wr_data,
  output logic [3:0]        ram_wr_be,
  output logic [3:0]        sh_offset,
  output logic [31:0]       sh_wr_data,
  output logic [3:0]        sh_wr_be,
  output logic              dreg_rd_en,
  output logic              dreg_wr_en,
  input  logic [31:0]       dreg_rd_data,
  output logic              aux_rd_en,
  output logic              aux_wr_en,
  input  logic [31:0]       aux_rd_data,
  output logic              cpu_ev_valid,
  output logic [7:0]        cpu_ev_region,
  output logic [7:0]        cpu_ev_master,
  output logic              cpu_ev_write,
  output logic [31:0]       cpu_ev_addr,
  output logic              dma_ev_valid,
  output logic [7:0]        dma_ev_region,
  output logic [7:0]        dma_ev_master,
  output logic [31:0]       dma_ev_addr
);

  localparam logic [7:0]  RGN_NONE  = 8'd0;
  localparam logic [7:0]  RGN_RAM   = 8'd2;
  localparam logic [7:0]  RGN_DREG  = 8'd4;
  localparam logic [7:0]  RGN_AUX   = 8'd5;
  localparam logic [27:0] DREG_PAGE = 28'h1F8_0152;
  localparam logic [27:0] AUX_PAGE  = 28'h1F8_0107;

  function automatic logic [7:0] region_of(input logic [31:0] a);
    if (a[31:RAM_AW] == '0)        return RGN_RAM;
    else if (a[31:4] == DREG_PAGE) return RGN_DREG;
    else if (a[31:4] == AUX_PAGE)  return RGN_AUX;
    else                           return RGN_NONE;
  endfunction

  function automatic logic [RAM_AW-1:0] word_of(input logic [31:0] a);
    return {a[RAM_AW-1:2], 2'b00};
  endfunction

  logic              pend_v;
  logic [31:0]       pend_addr;
  logic              cpu_rv;
  logic [7:0]        cpu_rsel;
  logic              dma_rv;
  logic              dma_rhit;

  logic [7:0]  cpu_rgn, dma_rgn, issue_rgn;
  logic        cpu_ram_rd, dma_ram, cpu_issue, cpu_take_ram;
  logic [31:0] cpu_eff_addr;

  assign cpu_rgn      = region_of(cpu_addr);
  assign dma_rgn      = region_of(dma_rd_addr);
  assign cpu_ram_rd   = cpu_rd_en && cpu_rgn == RGN_RAM;
  assign dma_ram      = dma_rd_en && dma_rgn == RGN_RAM;
  assign cpu_take_ram = pend_v ? !dma_ram : (cpu_ram_rd && !dma_ram);
  assign cpu_issue    = pend_v ? !dma_ram : (cpu_rd_en && !(cpu_ram_rd && dma_ram));
  assign issue_rgn    = pend_v ? RGN_RAM : cpu_rgn;
  assign cpu_eff_addr = pend_v ? pend_addr : cpu_addr;

  assign ram_rd_en     = dma_ram || cpu_take_ram;
  assign ram_rd_addr   = dma_ram ? word_of(dma_rd_addr) : word_of(cpu_eff_addr);
  assign ram_rd_master = dma_ram ? DMA_ID : CPU_ID;

  assign ram_wr_en   = cpu_wr_en && cpu_rgn == RGN_RAM;
  assign ram_wr_addr = word_of(cpu_addr);
  assign ram_wr_data = cpu_wr_data;
  assign ram_wr_be   = cpu_wr_be;

  assign sh_offset  = cpu_addr[3:0];
  assign sh_wr_data = cpu_wr_data;
  assign sh_wr_be   = cpu_wr_be;
  assign dreg_rd_en = cpu_rd_en && !pend_v && cpu_rgn == RGN_DREG;
  assign dreg_wr_en = cpu_wr_en && cpu_rgn == RGN_DREG;
  assign aux_rd_en  = cpu_rd_en && !pend_v && cpu_rgn == RGN_AUX;
  assign aux_wr_en  = cpu_wr_en && cpu_rgn == RGN_AUX;

  always_comb begin
    cpu_rd_data = '0;
    if (cpu_rv) begin
      case (cpu_rsel)
        RGN_RAM:  cpu_rd_data = ram_rd_data;
        RGN_DREG: cpu_rd_data = dreg_rd_data;
        RGN_AUX:  cpu_rd_data = aux_rd_data;
        default:  cpu_rd_data = '0;
      endcase
    end
  end

  assign cpu_rd_valid  = cpu_rv;
  assign dma_rd_valid  = dma_rv;
  assign dma_rd_data   = (dma_rv && dma_rhit) ? ram_rd_data : '0;
  assign cpu_ev_master = CPU_ID;
  assign dma_ev_master = DMA_ID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v        <= 1'b0;
      pend_addr     <= '0;
      cpu_rv        <= 1'b0;
      cpu_rsel      <= RGN_NONE;
      dma_rv        <= 1'b0;
      dma_rhit      <= 1'b0;
      cpu_ev_valid  <= 1'b0;
      cpu_ev_region <= RGN_NONE;
      cpu_ev_write  <= 1'b0;
      cpu_ev_addr   <= '0;
      dma_ev_valid  <= 1'b0;
      dma_ev_region <= RGN_NONE;
      dma_ev_addr   <= '0;
    end else begin
      pend_v <= pend_v ? dma_ram : (cpu_ram_rd && dma_ram);
      if (!pend_v) pend_addr <= cpu_addr;
      cpu_rv   <= cpu_issue;
      cpu_rsel <= issue_rgn;
      dma_rv   <= dma_rd_en;
      dma_rhit <= dma_ram;
      cpu_ev_valid  <= cpu_issue || cpu_wr_en;
      cpu_ev_region <= cpu_wr_en ? cpu_rgn : issue_rgn;
      cpu_ev_write  <= cpu_wr_en;
      cpu_ev_addr   <= cpu_wr_en ? cpu_addr : cpu_eff_addr;
      dma_ev_valid  <= dma_rd_en;
      dma_ev_region <= dma_rgn;
      dma_ev_addr   <= dma_rd_addr;
    end
  end

endmodule

// File: rtl/phys_addr_router_sva.sv
module phys_addr_router_sva #(
  parameter int RAM_AW = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rd_en,
  input logic              cpu_wr_en,
  input logic [31:0]       cpu_addr,
  input logic              cpu_rd_valid,
  input logic              dma_rd_en,
  input logic [31:0]       dma_rd_addr,
  input logic              dma_rd_valid,
  input logic              ram_rd_en,
  input logic [RAM_AW-1:0] ram_rd_addr,
  input logic [7:0]        ram_rd_master,
  input logic              ram_wr_en,
  input logic              dreg_wr_en,
  input logic              aux_wr_en,
  input logic              cpu_ev_valid,
  input logic              cpu_ev_write,
  input logic              dma_ev_valid
);

  logic cpu_in_ram, dma_in_ram, cpu_unmapped;
  assign cpu_in_ram   = cpu_addr[31:RAM_AW] == '0;
  assign dma_in_ram   = dma_rd_addr[31:RAM_AW] == '0;
  assign cpu_unmapped = !cpu_in_ram && cpu_addr[31:4] != 28'h1F8_0152
                        && cpu_addr[31:4] != 28'h1F8_0107;

  assert_wr_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_wr_en, dreg_wr_en, aux_wr_en}));

  assert_cpu_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && !(cpu_in_ram && dma_rd_en && dma_in_ram)) |=> cpu_rd_valid);

  assert_dma_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd_en && dma_in_ram) |-> (ram_rd_en && ram_rd_master == 8'd4
                                   && ram_rd_addr[RAM_AW-1:2] == dma_rd_addr[RAM_AW-1:2]));

  assert_dma_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_en |=> dma_rd_valid);

  assert_collision_defer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && cpu_in_ram && dma_rd_en && dma_in_ram) |=> !cpu_rd_valid);

  assert_unmapped_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && cpu_unmapped) |-> !(ram_wr_en || dreg_wr_en || aux_wr_en));

  assert_write_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_en |=> (cpu_ev_valid && cpu_ev_write));

  assert_dma_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_en |=> dma_ev_valid);

  assert_quiet_reset_R9: assert property (@(posedge clk)
    !rst_n |=> !(cpu_ev_valid || dma_ev_valid || cpu_rd_valid || dma_rd_valid));

endmodule

bind phys_addr_router phys_addr_router_sva #(.RAM_AW(RAM_AW)) i_sva (.*);

// File: tb/test_phys_addr_router.sv
`timescale 1ns/1ps
module test_phys_addr_router;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;
  localparam logic [7:0] R_NONE = 8'd0, R_RAM = 8'd2, R_DREG = 8'd4, R_AUX = 8'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic cpu_rd_en = 0, cpu_wr_en = 0;
  logic [31:0] cpu_addr = 0, cpu_wr_data = 0;
  logic [3:0] cpu_wr_be = 0;
  logic [31:0] cpu_rd_data; logic cpu_rd_valid;
  logic dma_rd_en = 0; logic [31:0] dma_rd_addr = 0;
  logic [31:0] dma_rd_data; logic dma_rd_valid;
  logic ram_rd_en, ram_wr_en; logic [AW-1:0] ram_rd_addr, ram_wr_addr;
  logic [7:0] ram_rd_master; logic [31:0] ram_rd_data = 0, ram_wr_data; logic [3:0] ram_wr_be;
  logic [3:0] sh_offset, sh_wr_be; logic [31:0] sh_wr_data;
  logic dreg_rd_en, dreg_wr_en, aux_rd_en, aux_wr_en;
  logic [31:0] dreg_rd_data = 0, aux_rd_data = 0;
  logic cpu_ev_valid, cpu_ev_write, dma_ev_valid;
  logic [7:0] cpu_ev_region, cpu_ev_master, dma_ev_region, dma_ev_master;
  logic [31:0] cpu_ev_addr, dma_ev_addr;

  phys_addr_router i_phys_addr_router (.*);

  logic [31:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  always @(posedge clk) begin
    if (ram_wr_en)
      for (int b = 0; b < 4; b++)
        if (ram_wr_be[b]) mem[ram_wr_addr[9:2]][8*b +: 8] <= ram_wr_data[8*b +: 8];
    if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr[9:2]];
    dreg_rd_data <= dreg_rd_en ? (32'hD1A0_0000 | {28'h0, sh_offset}) : 32'h0;
    aux_rd_data  <= aux_rd_en  ? (32'hA0C0_0000 | {28'h0, sh_offset}) : 32'h0;
  end

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] q_cpu[$], q_dma[$];
  logic [48:0] q_cev[$], q_dev[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [48:0] ev(input logic w, input logic [7:0] r, input logic [7:0] m, input logic [31:0] a);
    return {w, r, m, a};
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (cpu_rd_valid) begin
      if (q_cpu.size() == 0) chk(0, "R3 unexpected cpu valid", cpu_rd_data, 0);
      else begin logic [31:0] e; e = q_cpu.pop_front(); chk(cpu_rd_data === e, "R3 cpu data", cpu_rd_data, e); end
    end
    if (dma_rd_valid) begin
      if (q_dma.size() == 0) chk(0, "R4 unexpected dma valid", dma_rd_data, 0);
      else begin logic [31:0] e; e = q_dma.pop_front(); chk(dma_rd_data === e, "R4 dma data", dma_rd_data, e); end
    end
    if (cpu_ev_valid) begin
      logic [48:0] a; a = {cpu_ev_write, cpu_ev_region, cpu_ev_master, cpu_ev_addr};
      if (q_cev.size() == 0) chk(0, "R7 unexpected cpu event", a, 0);
      else begin logic [48:0] e; e = q_cev.pop_front(); chk(a === e, "R7 cpu event", a, e); end
    end
    if (dma_ev_valid) begin
      logic [48:0] a; a = {1'b0, dma_ev_region, dma_ev_master, dma_ev_addr};
      if (q_dev.size() == 0) chk(0, "R8 unexpected dma event", a, 0);
      else begin logic [48:0] e; e = q_dev.pop_front(); chk(a === e, "R8 dma event", a, e); end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cpu_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input logic [7:0] r);
    q_cev.push_back(ev(1'b1, r, 8'd2, a));
    @(negedge clk);
    cpu_wr_en = 1; cpu_addr = a; cpu_wr_data = d; cpu_wr_be = be;
    #1;
    case (r)
      R_RAM: chk(ram_wr_en && ram_wr_addr == {a[20:2], 2'b00} && ram_wr_data == d && ram_wr_be == be,
                 "R1 ram write forward", {ram_wr_en, ram_wr_addr, ram_wr_be}, {1'b1, a[20:2], 2'b00, be});
      R_DREG: chk(dreg_wr_en && !ram_wr_en && sh_offset == a[3:0] && sh_wr_data == d,
                  "R2 dreg write forward", {dreg_wr_en, sh_offset}, {1'b1, a[3:0]});
      R_AUX: chk(aux_wr_en && !dreg_wr_en && sh_offset == a[3:0] && sh_wr_be == be,
                 "R10 aux write forward", {aux_wr_en, sh_offset}, {1'b1, a[3:0]});
      default: chk(!(ram_wr_en || dreg_wr_en || aux_wr_en), "R6 unmapped write dropped",
                   {ram_wr_en, dreg_wr_en, aux_wr_en}, 3'b000);
    endcase
    @(negedge clk);
    cpu_wr_en = 0; cpu_wr_be = 0;
  endtask

  task automatic cpu_rd(input logic [31:0] a, input logic [31:0] d, input logic [7:0] r, input string req);
    q_cpu.push_back(d);
    q_cev.push_back(ev(1'b0, r, 8'd2, a));
    @(negedge clk);
    cpu_rd_en = 1; cpu_addr = a;
    @(negedge clk);
    cpu_rd_en = 0;
    chk(cpu_rd_valid === 1'b1, req, cpu_rd_valid, 1);
  endtask

  task automatic dma_rd(input logic [31:0] a, input logic [31:0] d, input logic [7:0] r);
    q_dma.push_back(d);
    q_dev.push_back(ev(1'b0, r, 8'd4, a));
    @(negedge clk);
    dma_rd_en = 1; dma_rd_addr = a;
    #1;
    if (r == R_RAM)
      chk(ram_rd_en && ram_rd_master == 8'd4 && ram_rd_addr == {a[20:2], 2'b00}, "R4 dma ram port",
          {ram_rd_en, ram_rd_master, ram_rd_addr}, {1'b1, 8'd4, a[20:2], 2'b00});
    else chk(!ram_rd_en, "R4 dma outside ram", ram_rd_en, 0);
    @(negedge clk);
    dma_rd_en = 0;
    chk(dma_rd_valid === 1'b1, "R4 dma latency", dma_rd_valid, 1);
  endtask

  initial begin
    // R9: requests during reset produce nothing
    repeat (2) @(negedge clk);
    cpu_rd_en = 1; cpu_addr = 32'h1F80_2000; dma_rd_en = 1; dma_rd_addr = 32'h40;
    repeat (2) @(negedge clk);
    chk(!(cpu_ev_valid || dma_ev_valid || cpu_rd_valid || dma_rd_valid), "R9 quiet in reset",
        {cpu_ev_valid, dma_ev_valid, cpu_rd_valid, dma_rd_valid}, 0);
    cpu_rd_en = 0; dma_rd_en = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(!(cpu_ev_valid || dma_ev_valid), "R9 no event after release", {cpu_ev_valid, dma_ev_valid}, 0);

    // R1 writes and partial byte-enable write
    cpu_wr(32'h100, 32'h1111_1111, 4'hF, R_RAM);
    cpu_wr(32'h104, 32'h2222_2222, 4'hF, R_RAM);
    cpu_wr(32'h108, 32'h3333_3333, 4'hF, R_RAM);
    cpu_wr(32'h10C, 32'h4444_4444, 4'hF, R_RAM);
    cpu_wr(32'h107, 32'h0000_AB00, 4'b0010, R_RAM);
    cpu_rd(32'h104, 32'h2222_AB22, R_RAM, "R1 R3 byte-enable merge read latency");
    cpu_rd(32'h10C, 32'h4444_4444, R_RAM, "R3 ram read latency");

    // R2 DMA register shell
    cpu_wr(32'h1F80_1528, 32'h0000_0040, 4'hF, R_DREG);
    cpu_rd(32'h1F80_152C, 32'hD1A0_000C, R_DREG, "R2 dreg read latency");
    // R10 auxiliary shell
    cpu_wr(32'h1F80_107B, 32'h5A5A_5A5A, 4'b1001, R_AUX);
    cpu_rd(32'h1F80_1074, 32'hA0C0_0004, R_AUX, "R10 aux read latency");
    // R6 unmapped
    cpu_wr(32'h1F80_2000, 32'hFFFF_FFFF, 4'hF, R_NONE);
    cpu_rd(32'h1F80_2000, 32'h0, R_NONE, "R6 unmapped read");
    cpu_rd(32'h0020_0000, 32'h0, R_NONE, "R6 just above ram read");

    // R4 R8 DMA reads
    dma_rd(32'h100, 32'h1111_1111, R_RAM);
    dma_rd(32'h106, 32'h2222_AB22, R_RAM);
    dma_rd(32'h1F80_1520, 32'h0, R_DREG);

    // R5 collision: DMA wins twice, CPU read issued on third cycle
    q_cpu.push_back(32'h1111_1111);
    q_cev.push_back(ev(1'b0, R_RAM, 8'd2, 32'h100));
    q_dma.push_back(32'h3333_3333); q_dev.push_back(ev(1'b0, R_RAM, 8'd4, 32'h108));
    q_dma.push_back(32'h4444_4444); q_dev.push_back(ev(1'b0, R_RAM, 8'd4, 32'h10C));
    @(negedge clk);
    cpu_rd_en = 1; cpu_addr = 32'h100; dma_rd_en = 1; dma_rd_addr = 32'h108;
    #1;
    chk(ram_rd_master == 8'd4 && ram_rd_addr == 21'h108, "R5 dma wins port",
        {ram_rd_master, ram_rd_addr}, {8'd4, 21'h108});
    @(negedge clk);
    cpu_rd_en = 0; dma_rd_addr = 32'h10C;
    #1;
    chk(!cpu_rd_valid && ram_rd_master == 8'd4, "R5 cpu held while dma repeats",
        {cpu_rd_valid, ram_rd_master}, {1'b0, 8'd4});
    @(negedge clk);
    dma_rd_en = 0;
    #1;
    chk(!cpu_rd_valid && ram_rd_en && ram_rd_master == 8'd2 && ram_rd_addr == 21'h100,
        "R5 parked cpu read issued", {cpu_rd_valid, ram_rd_master, ram_rd_addr}, {1'b0, 8'd2, 21'h100});
    @(negedge clk);
    chk(cpu_rd_valid === 1'b1, "R5 parked read valid", cpu_rd_valid, 1);
    @(negedge clk);
    chk(cpu_rd_valid === 1'b0, "R5 single valid", cpu_rd_valid, 0);

    repeat (4) @(negedge clk);
    chk(q_cpu.size() == 0 && q_dma.size() == 0, "R3 R4 all reads returned",
        q_cpu.size() + q_dma.size(), 0);
    chk(q_cev.size() == 0 && q_dev.size() == 0, "R7 R8 all events seen",
        q_cev.size() + q_dev.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule